// File: doc/BRIEF.md
# Loopback Frame Transmit Sequencer

This block sends a single frame for a network controller's loopback self-test. A start pulse latches a start page, a 16-bit byte count, an inhibit-CRC control and a FIFO refill threshold. A local DMA engine then reads the payload from buffer memory, one byte per accepted request, starting at byte address `page * 256`. It fills an internal FIFO until the FIFO is full. After that it refills the FIFO in bursts whenever the FIFO occupancy drops below the threshold.

At the same time a serializer sends one bit per clock. The order on the wire is:

1. A 56-bit alternating preamble.
2. The start-of-frame delimiter.
3. The payload bytes taken from the FIFO.
4. When CRC is not inhibited, a 32-bit CRC computed over the payload.

At the end the block raises a sticky transmitted flag. If the FIFO runs dry while payload bytes are still owed, the frame is abandoned and a sticky underrun flag is raised instead.

The two-bit loopback mode field only selects which loopback path the surrounding chip uses. It is decoded into three path-select outputs, and one of them forces the encoder/decoder stage to loop back.

Top module: `lbk_tx_seq`

## Requirements
- R1: After reset, `mem_req_o`, `ser_valid_o`, `busy_o`, `txdone_o` and `underrun_o` are all 0.
- R2: Mode code 2'b01 raises only `loop_int_o`, 2'b10 raises only `force_loop_o`, 2'b11 raises only `loop_ext_o`, and 2'b00 raises none of them.
- R3: After start, memory reads use the consecutive addresses `{page_i, 8'h00}`, `+1`, `+2` and so on. A read completes on a cycle with `mem_req_o` and `mem_ack_i` both high, with `mem_rdata_i` valid in that cycle. The first burst continues until the FIFO holds DEPTH (default 16) bytes or the count is exhausted.
- R4: After the first burst, a new burst starts only when FIFO occupancy has fallen below `thresh_i`. A burst then runs until the FIFO is full or the count is used up. No read is requested while the FIFO is full.
- R5: A frame performs exactly `count_i` memory reads. No request is made once the count reaches zero.
- R6: The serial stream starts the cycle after start, with one bit per cycle while `ser_valid_o` is high. It begins with 56 bits alternating 1,0,1,0… and then the delimiter bits 1,0,1,0,1,0,1,1.
- R7: Payload bytes follow the delimiter in memory order, each byte sent bit 0 first.
- R8: With `no_crc_i`=0, 32 more bits follow the payload. They are the complement of a CRC-32 with reflected polynomial 32'hEDB88320 and an all-ones preset, run over the payload bits in wire order, and they are sent bit 0 first. A zero-length frame therefore ends with 32 zero bits.
- R9: With `no_crc_i`=1, the stream ends right after the last payload bit.
- R10: After the last bit, `busy_o` and `ser_valid_o` fall and `txdone_o` is set. `txdone_o` stays set until the next accepted start, which clears it.
- R11: If the FIFO is empty when a payload byte is due, the stream stops after the current byte. `underrun_o` is then set, `txdone_o` stays 0, and memory requests cease.
- R12: A start pulse while `busy_o` is high is ignored, and the running frame is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-frame pulse |
| page_i | input | 8 | Start page (upper address byte) |
| count_i | input | 16 | Payload byte count |
| no_crc_i | input | 1 | 1 = do not append CRC |
| thresh_i | input | 5 | FIFO refill threshold in bytes |
| mode_i | input | 2 | Loopback mode code |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_ack_i | input | 1 | Memory accepts request, data valid this cycle |
| mem_rdata_i | input | 8 | Memory read data |
| ser_bit_o | output | 1 | Serial data bit |
| ser_valid_o | output | 1 | Serial bit strobe |
| busy_o | output | 1 | Frame in progress |
| txdone_o | output | 1 | Sticky frame-transmitted flag |
| underrun_o | output | 1 | Sticky underrun flag |
| loop_int_o | output | 1 | Internal serializer loopback selected |
| force_loop_o | output | 1 | Force encoder/decoder loopback |
| loop_ext_o | output | 1 | External loopback selected |

## Verification
Three things can happen in the same clock edge:

- The DMA pushes a refill byte into the FIFO.
- The serializer pops a byte from the FIFO.
- The refill decision reads the FIFO occupancy.

The bench provokes this overlap with long frames and with both low and high thresholds, under continuous and alternating memory acknowledges. At every burst start it infers the occupancy from the port activity: reads done minus payload bytes started. That occupancy must be one or two below the threshold. The other collision is the one between a due payload byte and an empty FIFO. The bench provokes it by stopping the acknowledges after the first fill. It then judges the exact bit count, the flag values and the silent memory port.

// File: rtl/lbk_pkg.sv
// Package lbk_pkg: shared phase type, framing constants and the bitwise
// reflected CRC-32 step used by the loopback transmit sequencer.
// Assumes: bits go onto the wire LSB first.
package lbk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_DATA = 2'd2,
        PH_FCS  = 2'd3
    } phase_t;

    localparam logic [7:0]  PRE_BYTE = 8'h55;          // 1,0,1,0... LSB first
    localparam logic [7:0]  SFD_BYTE = 8'hD5;          // 1,0,1,0,1,0,1,1 LSB first
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;   // reflected polynomial
    localparam int          HDR_BYTES = 8;             // 7 preamble + 1 delimiter

    // Advance the reflected CRC register by one wire bit.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY : 32'h0);
    endfunction

endpackage

// File: rtl/lbk_fifo.sv
// Module lbk_fifo: synchronous byte FIFO with occupancy count and flush.
// Assumes: DEPTH is a power of two; push when full and pop when empty are dropped.
module lbk_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/lbk_dma.sv
// Module lbk_dma: local DMA read engine. Fills the FIFO to full on start,
// then refills in bursts when occupancy drops below the threshold.
// Assumes: one byte per request/acknowledge handshake; addresses increment.
module lbk_dma #(
    parameter int DEPTH  = 16,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 5,
    localparam int ADDR_W = PAGE_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              stop,
    input  logic [PAGE_W-1:0] page,
    input  logic [15:0]       count,
    input  logic [CNT_W-1:0]  thresh,
    input  logic [CNT_W-1:0]  occ,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              push
);
    logic [15:0] remaining;
    logic        filling;
    logic        fifo_full;

    assign fifo_full = (occ == CNT_W'(DEPTH));
    assign req       = filling && (remaining != 16'd0) && !fifo_full;
    assign push      = req && ack;

    // Byte counter, address pointer and burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            addr      <= '0;
            filling   <= 1'b0;
        end else if (go) begin
            remaining <= count;
            addr      <= {page, 8'h00};
            filling   <= (count != 16'd0);
        end else if (stop) begin
            remaining <= '0;
            filling   <= 1'b0;
        end else begin
            if (push) begin
                remaining <= remaining - 16'd1;
                addr      <= addr + ADDR_W'(1);
            end
            if (filling) begin
                if (fifo_full || remaining == 16'd0) filling <= 1'b0;
            end else if (remaining != 16'd0 && occ < thresh) begin
                filling <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbk_ser.sv
// Module lbk_ser: bit serializer. Sends header, payload from the FIFO and an
// optional CRC-32, then flags done; flags underrun if a due byte is missing.
// Assumes: one wire bit per clock; bytes are sent LSB first.
module lbk_ser
    import lbk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        no_crc,
    input  logic [15:0] total,
    input  logic        fifo_empty,
    input  logic [7:0]  fifo_dout,
    output logic        fifo_pop,
    output logic        abort,
    output logic        bit_o,
    output logic        valid_o,
    output logic        done_o,
    output logic        urun_o
);
    phase_t      phase, ph_nx;
    logic [7:0]  shreg, load_byte;
    logic [2:0]  bitn, idx, idx_nx;
    logic [15:0] sent, sent_nx, total_q;
    logic        nocrc_q;
    logic [31:0] crc, crc_nx, fcs, fcs_nx;
    logic        load, finish;

    assign bit_o   = shreg[0];
    assign valid_o = (phase != PH_IDLE);
    assign crc_nx  = (phase == PH_DATA) ? crc_step(crc, shreg[0]) : crc;

    // Choose the next byte at the last bit of the current one.
    always_comb begin
        load      = 1'b0;
        load_byte = shreg;
        ph_nx     = phase;
        fifo_pop  = 1'b0;
        finish    = 1'b0;
        abort     = 1'b0;
        idx_nx    = idx;
        fcs_nx    = fcs;
        sent_nx   = sent;
        if (phase != PH_IDLE && bitn == 3'd7) begin
            if (phase == PH_HDR && idx != 3'(HDR_BYTES - 1)) begin
                load      = 1'b1;
                idx_nx    = idx + 3'd1;
                load_byte = (idx == 3'(HDR_BYTES - 2)) ? SFD_BYTE : PRE_BYTE;
            end else if (phase == PH_FCS) begin
                if (idx == 3'd3) begin
                    finish = 1'b1;
                end else begin
                    load      = 1'b1;
                    load_byte = fcs[7:0];
                    fcs_nx    = {8'h00, fcs[31:8]};
                    idx_nx    = idx + 3'd1;
                end
            end else if (sent != total_q) begin
                if (fifo_empty) begin
                    abort = 1'b1;
                end else begin
                    fifo_pop  = 1'b1;
                    load      = 1'b1;
                    load_byte = fifo_dout;
                    ph_nx     = PH_DATA;
                    sent_nx   = sent + 16'd1;
                end
            end else if (!nocrc_q) begin
                load      = 1'b1;
                load_byte = ~crc_nx[7:0];
                fcs_nx    = {8'h00, ~crc_nx[31:8]};
                idx_nx    = 3'd0;
                ph_nx     = PH_FCS;
            end else begin
                finish = 1'b1;
            end
        end
    end

    // Shift register, phase, CRC and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            bitn    <= '0;
            idx     <= '0;
            sent    <= '0;
            total_q <= '0;
            nocrc_q <= 1'b0;
            crc     <= '1;
            fcs     <= '0;
            done_o  <= 1'b0;
            urun_o  <= 1'b0;
        end else if (go) begin
            phase   <= PH_HDR;
            shreg   <= PRE_BYTE;
            bitn    <= '0;
            idx     <= '0;
            sent    <= '0;
            total_q <= total;
            nocrc_q <= no_crc;
            crc     <= '1;
            done_o  <= 1'b0;
            urun_o  <= 1'b0;
        end else if (finish || abort) begin
            phase <= PH_IDLE;
            if (finish) done_o <= 1'b1;
            if (abort)  urun_o <= 1'b1;
        end else if (phase != PH_IDLE) begin
            crc <= crc_nx;
            if (load) begin
                shreg <= load_byte;
                bitn  <= '0;
                phase <= ph_nx;
                idx   <= idx_nx;
                fcs   <= fcs_nx;
                sent  <= sent_nx;
            end else begin
                shreg <= {1'b0, shreg[7:1]};
                bitn  <= bitn + 3'd1;
            end
        end
    end
endmodule

// File: rtl/lbk_tx_seq.sv
// Module lbk_tx_seq: loopback frame transmit sequencer top. Connects the DMA
// engine, FIFO and serializer, and decodes the loopback mode.
// Assumes: start is accepted only while idle; page is the upper address byte.
module lbk_tx_seq #(
    parameter int DEPTH  = 16,
    parameter int PAGE_W = 8,
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int ADDR_W = PAGE_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [15:0]       count_i,
    input  logic              no_crc_i,
    input  logic [CNT_W-1:0]  thresh_i,
    input  logic [1:0]        mode_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              ser_bit_o,
    output logic              ser_valid_o,
    output logic              busy_o,
    output logic              txdone_o,
    output logic              underrun_o,
    output logic              loop_int_o,
    output logic              force_loop_o,
    output logic              loop_ext_o
);
    logic             go;
    logic             abort;
    logic             push;
    logic             pop;
    logic             fifo_empty;
    logic [7:0]       fifo_dout;
    logic [CNT_W-1:0] fifo_cnt;
    logic [CNT_W-1:0] thresh_q;

    assign busy_o = ser_valid_o;
    assign go     = start_i && !busy_o;

    // Loopback path select decode.
    always_comb begin
        loop_int_o   = (mode_i == 2'b01);
        force_loop_o = (mode_i == 2'b10);
        loop_ext_o   = (mode_i == 2'b11);
    end

    // Threshold latched at start so a frame uses one setting.
    always_ff @(posedge clk) begin
        if (!rst_n)  thresh_q <= '0;
        else if (go) thresh_q <= thresh_i;
    end

    lbk_dma #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_dma (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .stop   (abort),
        .page   (page_i),
        .count  (count_i),
        .thresh (thresh_q),
        .occ    (fifo_cnt),
        .ack    (mem_ack_i),
        .req    (mem_req_o),
        .addr   (mem_addr_o),
        .push   (push)
    );

    lbk_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (go || abort),
        .push  (push),
        .din   (mem_rdata_i),
        .pop   (pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .count (fifo_cnt)
    );

    lbk_ser u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .no_crc     (no_crc_i),
        .total      (count_i),
        .fifo_empty (fifo_empty),
        .fifo_dout  (fifo_dout),
        .fifo_pop   (pop),
        .abort      (abort),
        .bit_o      (ser_bit_o),
        .valid_o    (ser_valid_o),
        .done_o     (txdone_o),
        .urun_o     (underrun_o)
    );
endmodule

// File: rtl/lbk_tx_seq_chk.sv
// Module lbk_tx_seq_chk: property checker bound to lbk_tx_seq.
// Assumes: occ is the FIFO occupancy seen inside the top.
module lbk_tx_seq_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] occ,
    input logic             mem_req_o,
    input logic             ser_valid_o,
    input logic             busy_o,
    input logic             txdone_o,
    input logic             underrun_o,
    input logic             loop_int_o,
    input logic             force_loop_o,
    input logic             loop_ext_o
);
    // R4
    no_req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (occ < CNT_W'(DEPTH)));

    // R5
    req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    // R11
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(txdone_o && underrun_o));

    // R11
    underrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> !mem_req_o);

    // R10
    done_after_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txdone_o) |-> ($past(ser_valid_o) && !ser_valid_o));

    // R2
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loop_int_o, force_loop_o, loop_ext_o}));
endmodule

bind lbk_tx_seq lbk_tx_seq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .occ          (fifo_cnt),
    .mem_req_o    (mem_req_o),
    .ser_valid_o  (ser_valid_o),
    .busy_o       (busy_o),
    .txdone_o     (txdone_o),
    .underrun_o   (underrun_o),
    .loop_int_o   (loop_int_o),
    .force_loop_o (force_loop_o),
    .loop_ext_o   (loop_ext_o)
);

// File: tb/lbk_tx_seq_test.sv
module lbk_tx_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  page_i = '0;
    logic [15:0] count_i = '0;
    logic        no_crc_i = 1'b0;
    logic [4:0]  thresh_i = '0;
    logic [1:0]  mode_i = '0;
    logic        mem_req_o, mem_ack_i;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_rdata_i;
    logic        ser_bit_o, ser_valid_o, busy_o, txdone_o, underrun_o;
    logic        loop_int_o, force_loop_o, loop_ext_o;

    int n_chk = 0;
    int n_fail = 0;

    // memory model and capture state
    int   ack_mode = 0;
    int   ack_limit = 0;
    logic tgl = 1'b0;
    logic clr = 1'b0;
    int   rd_cnt = 0;
    int   nb = 0;
    logic [15:0] addr_log [0:255];
    logic        bits [0:1023];
    logic        exp_bits [0:1023];
    int   exp_n;
    // refill monitor
    int   mon_thr = 0;
    int   n_rise = 0;
    int   bad_rise = 0;
    int   first_len = -1;
    logic req_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    assign mem_rdata_i = pat(mem_addr_o);
    assign mem_ack_i   = (rd_cnt < ack_limit) && (ack_mode == 1 || (ack_mode == 2 && tgl));

    lbk_tx_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
        .count_i(count_i), .no_crc_i(no_crc_i), .thresh_i(thresh_i),
        .mode_i(mode_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .ser_bit_o(ser_bit_o), .ser_valid_o(ser_valid_o), .busy_o(busy_o),
        .txdone_o(txdone_o), .underrun_o(underrun_o),
        .loop_int_o(loop_int_o), .force_loop_o(force_loop_o),
        .loop_ext_o(loop_ext_o)
    );

    always @(negedge clk) tgl <= ~tgl;

    // capture handshakes and serial bits at the clock edge
    always @(posedge clk) begin
        if (clr) begin
            rd_cnt <= 0;
            nb     <= 0;
        end else begin
            if (mem_req_o && mem_ack_i) begin
                if (rd_cnt < 256) addr_log[rd_cnt] <= mem_addr_o;
                rd_cnt <= rd_cnt + 1;
            end
            if (ser_valid_o) begin
                if (nb < 1024) bits[nb] <= ser_bit_o;
                nb <= nb + 1;
            end
        end
    end

    // burst-start monitor: occupancy inferred from ports
    always @(negedge clk) begin
        if (mem_req_o && !req_q) begin
            n_rise = n_rise + 1;
            if (n_rise > 1) begin
                int started;
                int occ_i;
                started = (nb >= 64) ? ((nb - 64) / 8 + 1) : 0;
                occ_i = rd_cnt - started;
                if (occ_i > mon_thr - 1 || occ_i < mon_thr - 2) bad_rise = bad_rise + 1;
            end
        end
        if (!mem_req_o && req_q && n_rise == 1 && first_len < 0) first_len = rd_cnt;
        req_q = mem_req_o;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            exp_bits[exp_n] = b[i];
            exp_n++;
        end
    endtask

    task automatic build_exp(input logic [7:0] page, input int len, input logic nocrc);
        logic [31:0] c;
        logic        fb;
        logic [7:0]  d;
        exp_n = 0;
        for (int k = 0; k < 7; k++) add_byte(8'h55);
        add_byte(8'hD5);
        c = 32'hFFFFFFFF;
        for (int k = 0; k < len; k++) begin
            d = pat({page, 8'h00} + 16'(k));
            add_byte(d);
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ d[i];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        if (!nocrc) begin
            c = ~c;
            for (int k = 0; k < 4; k++) add_byte(c[8*k +: 8]);
        end
    endtask

    // start one frame and wait for it to end
    task automatic run_frame(input logic [7:0] page, input int len, input logic nocrc,
                             input int thr, input int amode, input int alimit, input logic poke);
        @(negedge clk);
        page_i = page; count_i = 16'(len); no_crc_i = nocrc; thresh_i = 5'(thr);
        ack_mode = amode; ack_limit = alimit; mon_thr = thr;
        n_rise = 0; bad_rise = 0; first_len = -1;
        start_i = 1'b1; clr = 1'b1;
        @(negedge clk);
        start_i = 1'b0; clr = 1'b0;
        // R10: accepted start clears the sticky flags
        check(!txdone_o && !underrun_o && busy_o, "R10 start clears flags", {txdone_o, underrun_o}, 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            count_i = 16'd3; page_i = 8'hEE; no_crc_i = ~nocrc;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int t = 0; t < 5000 && busy_o; t++) @(negedge clk);
        check(!busy_o, "R10 frame ends (watchdog)", busy_o, 0);
        @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        int bad;
        int first;
        bad = 0; first = -1;
        check(nb == exp_n, {req, " bit count"}, nb, exp_n);
        for (int i = 0; i < exp_n && i < nb; i++)
            if (bits[i] !== exp_bits[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        check(bad == 0, {req, " bit mismatches (first index shown as actual)"}, first, -1);
    endtask

    task automatic check_addrs(input logic [7:0] page, input int len);
        int bad;
        bad = 0;
        for (int i = 0; i < len && i < 256; i++)
            if (addr_log[i] !== ({page, 8'h00} + 16'(i))) bad++;
        check(bad == 0, "R3 consecutive addresses from page base", bad, 0);
        check(rd_cnt == len, "R5 read count equals byte count", rd_cnt, len);
        check(!mem_req_o, "R5 no request after count exhausted", mem_req_o, 0);
    endtask

    task automatic t_reset;
        check(!mem_req_o && !ser_valid_o && !busy_o && !txdone_o && !underrun_o,
              "R1 reset state", {mem_req_o, ser_valid_o, busy_o, txdone_o, underrun_o}, 0);
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            logic [2:0] e;
            mode_i = 2'(m);
            #1;
            e = (m == 1) ? 3'b100 : (m == 2) ? 3'b010 : (m == 3) ? 3'b001 : 3'b000;
            check({loop_int_o, force_loop_o, loop_ext_o} == e, "R2 loopback mode decode",
                  {loop_int_o, force_loop_o, loop_ext_o}, e);
        end
        mode_i = 2'b00;
    endtask

    task automatic t_basic;
        // R6 R7 R8 R12: 20-byte frame with CRC, start poked while busy
        build_exp(8'h12, 20, 1'b0);
        run_frame(8'h12, 20, 1'b0, 4, 1, 1000, 1'b1);
        cmp_stream("R6 R7 R8 R12 frame with CRC");
        check_addrs(8'h12, 20);
        check(txdone_o && !underrun_o, "R10 transmitted flag set", txdone_o, 1);
        repeat (3) @(negedge clk);
        check(txdone_o, "R10 transmitted flag sticky", txdone_o, 1);
    endtask

    task automatic t_nocrc;
        build_exp(8'h40, 5, 1'b1);
        run_frame(8'h40, 5, 1'b1, 4, 1, 1000, 1'b0);
        cmp_stream("R9 inhibit CRC");
        check_addrs(8'h40, 5);
    endtask

    task automatic t_zero;
        build_exp(8'h07, 0, 1'b0);
        run_frame(8'h07, 0, 1'b0, 4, 1, 1000, 1'b0);
        cmp_stream("R8 zero-length frame CRC of nothing");
        check(rd_cnt == 0, "R5 no reads for zero count", rd_cnt, 0);
        check(txdone_o, "R10 zero-length done", txdone_o, 1);
    endtask

    task automatic t_refill_low;
        build_exp(8'h21, 40, 1'b0);
        run_frame(8'h21, 40, 1'b0, 4, 1, 1000, 1'b0);
        cmp_stream("R7 R8 long frame low threshold");
        check(first_len == DEPTH, "R3 first burst fills FIFO", first_len, DEPTH);
        check(n_rise >= 2, "R4 refill bursts occurred", n_rise, 2);
        check(bad_rise == 0, "R4 refill starts just below threshold", bad_rise, 0);
        check_addrs(8'h21, 40);
    endtask

    task automatic t_refill_high;
        build_exp(8'h33, 48, 1'b0);
        run_frame(8'h33, 48, 1'b0, 12, 2, 1000, 1'b0);
        cmp_stream("R7 alternating acknowledge high threshold");
        check(n_rise >= 3, "R4 several refill bursts", n_rise, 3);
        check(bad_rise == 0, "R4 refill starts just below high threshold", bad_rise, 0);
        check_addrs(8'h33, 48);
    endtask

    task automatic t_underrun;
        run_frame(8'h50, 30, 1'b0, 4, 1, DEPTH, 1'b0);
        check(nb == 64 + 8 * DEPTH, "R11 stream stops after buffered bytes", nb, 64 + 8 * DEPTH);
        check(underrun_o, "R11 underrun flag set", underrun_o, 1);
        check(!txdone_o, "R11 transmitted flag clear", txdone_o, 0);
        check(!mem_req_o, "R11 requests stopped", mem_req_o, 0);
        check(rd_cnt == DEPTH, "R11 only fill reads done", rd_cnt, DEPTH);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_basic();
        t_nocrc();
        t_zero();
        t_refill_low();
        t_refill_high();
        t_underrun();
        t_basic();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule